// File: doc/BRIEF.md
# Optical-Drive Controller Host Register Interface

This block is the byte-wide register file that a host processor uses to talk to an optical-drive controller. The host writes one of four even offsets: a control byte, a command byte, a parameter byte or a transfer-enable byte. It reads back a master status byte, the queued status reply bytes and the sub-channel bytes. Parameter bytes collect in a small FIFO that downstream command logic drains. The command byte is split into its fields and announced with a one-cycle strobe.

The controller side loads a complete four-byte status reply in one cycle. Loading a reply replaces whatever the host had not yet read. Sub-channel bytes are pushed one at a time. Two interrupt flags are kept, one for the sub-processor and one for DMA completion. Each flag has its own mask, and the host clears the flags, sets the masks and issues a soft reset through the same control byte.

Top module: `cdc_host_regs`

## Requirements
- R1: Writing offset 0x0 with bit 7 set clears the sub-processor flag, and with bit 6 set clears the DMA flag. A flag whose bit is 0 keeps its value.
- R2: Each write to offset 0x0 loads the sub-processor mask from bit 1 and the DMA mask from bit 0. Each interrupt output is its flag while the mask is 0, and is low while the mask is 1. Master status always shows the unmasked flags.
- R3: Writing offset 0x0 with bit 2 set empties the parameter, status and sub-code queues and clears both flags. This takes priority over any set event in the same cycle.
- R4: A write to offset 0x2 raises `cmd_valid_o` for exactly the next cycle. The decoded fields are: play class = bit 7, reply interrupt request = bit 6, status request = bit 5, code = bits 4:0. The fields hold until the next command write.
- R5: Parameter bytes written at offset 0x4 leave in write order through `param_data_o`/`param_pop_i`, with `param_cnt_o` giving the fill level. The queue holds 8 bytes. A write when it is full discards the oldest byte and stores the new one.
- R6: A write to offset 0x6 sets `dma_en_o` from bit 4 and `pio_en_o` from bit 3.
- R7: A read at offset 0x0 returns the sub-processor flag in bit 7, the DMA flag in bit 6, `xfer_phase_i` in bit 5, `dma_busy_i` in bit 4, status available in bit 1 and `sub_ready_i` in bit 0. The other bits read 0.
- R8: A `stat_load_i` pulse flushes the status queue and stores four bytes, with `stat_reply_i[7:0]` read first. Each read at offset 0x2 returns and removes the next byte.
- R9: A status load sets the sub-processor flag only when the last command byte had its reply interrupt bit set.
- R10: A `dma_done_i` pulse sets the DMA flag. A set and a clear in the same cycle leave the flag set.
- R11: A read at offset 0xC returns bit 0 = sub-code queue not empty and bit 1 = `subq_overrun_i`, with the other bits 0. A read at offset 0xD returns and removes one sub-code byte, or 0x00 when the queue is empty.
- R12: Reads at any offset other than 0x0, 0x2, 0xC and 0xD return 0xFF. A read at 0x2 with the status queue empty returns 0x00 and changes nothing.
- R13: Writes to any offset other than 0x0, 0x2, 0x4 and 0x6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe (pops on the queue offsets) |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| cmd_valid_o | output | 1 | One-cycle strobe after a command write |
| cmd_play_o | output | 1 | Command is of the play class |
| cmd_irq_req_o | output | 1 | Interrupt requested on status reply |
| cmd_stat_req_o | output | 1 | Status reply requested |
| cmd_code_o | output | 5 | Command code |
| param_pop_i | input | 1 | Consume one parameter byte |
| param_data_o | output | 8 | Oldest parameter byte |
| param_cnt_o | output | 4 | Parameter bytes held |
| dma_en_o | output | 1 | DMA transfer enable |
| pio_en_o | output | 1 | Programmed-I/O transfer enable |
| stat_load_i | input | 1 | Load a four-byte status reply |
| stat_reply_i | input | 32 | Reply bytes, byte 0 in bits 7:0 |
| subq_push_i | input | 1 | Push one sub-code byte |
| subq_data_i | input | 8 | Sub-code byte |
| subq_overrun_i | input | 1 | Sub-code overrun indication |
| xfer_phase_i | input | 1 | Software transfer phase indication |
| dma_busy_i | input | 1 | DMA channel busy indication |
| sub_ready_i | input | 1 | Sub-processor ready indication |
| dma_done_i | input | 1 | DMA completion event |
| sub_irq_o | output | 1 | Sub-processor interrupt |
| dma_irq_o | output | 1 | DMA interrupt |

## Verification
Most internal state is visible at the ports within one cycle. A wrong flag shows up in master status bits 7:6 and on the interrupt pins one cycle after the event, and a wrong queue pointer shows up as a wrong byte or fill level on the next pop. Queue faults that need a wrap, such as a dropped-oldest error, only appear after the ninth parameter write. A stale status byte after a flush only appears when a reload follows a partial read. The bench therefore drives those sequences on purpose and sweeps every command byte, every transfer byte and every combination of clear and mask bits.

// File: rtl/cdc_hrif_pkg.sv
package cdc_hrif_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_PARAM  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_XFER   = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_SUBST  = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_SUBDAT = 4'hD;

  // field order follows the bit order of the command byte
  typedef struct packed {
    logic       play;
    logic       irq_req;
    logic       stat_req;
    logic [4:0] code;
  } cmd_t;

  localparam int IRQ_DMA = 0;
  localparam int IRQ_SUB = 1;
  localparam int IRQ_N   = 2;
endpackage

// File: rtl/cdc_hrif_fifo.sv
module cdc_hrif_fifo #(
  parameter int W         = 8,
  parameter int DEPTH     = 8,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       empty_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_pop, do_push, drop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty_o;

  generate
    if (OVERWRITE) begin : g_overwrite
      assign drop    = push_i & full & ~do_pop;
      assign do_push = push_i;
    end else begin : g_keep
      assign drop    = 1'b0;
      assign do_push = push_i & (~full | do_pop);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + PW'(1);
      if (do_pop | drop) rd_q <= rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop | drop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= data_i;
  end

  assign data_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cdc_hrif_statq.sv
module cdc_hrif_statq #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   load_i,
  input  logic [N*W-1:0]         reply_i,
  input  logic                   pop_i,
  output logic [W-1:0]           data_o,
  output logic [$clog2(N+1)-1:0] cnt_o,
  output logic                   nempty_o
);
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic [W-1:0]  byte_q [N];
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;

  assign nempty_o = (cnt_q != '0);

  // load replaces the whole queue; no partial append
  generate
    for (genvar i = 0; i < N; i++) begin : g_byte
      always_ff @(posedge clk_i) begin
        if (load_i && !clr_i) byte_q[i] <= reply_i[i*W +: W];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      cnt_q <= CW'(N);
    end else if (pop_i && nempty_o) begin
      idx_q <= idx_q + IW'(1);
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign data_o = nempty_o ? byte_q[idx_q] : '0;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cdc_hrif_irq.sv
module cdc_hrif_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // soft reset > set > host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (kill_i) flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_i;
endmodule

// File: rtl/cdc_host_regs.sv
module cdc_host_regs
  import cdc_hrif_pkg::*;
#(
  parameter int PARAM_DEPTH = 8,
  parameter int SUBQ_DEPTH  = 16,
  parameter int STAT_BYTES  = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             rd_en_i,
  input  logic [3:0]                       addr_i,
  input  logic [7:0]                       wdata_i,
  output logic [7:0]                       rdata_o,
  output logic                             cmd_valid_o,
  output logic                             cmd_play_o,
  output logic                             cmd_irq_req_o,
  output logic                             cmd_stat_req_o,
  output logic [4:0]                       cmd_code_o,
  input  logic                             param_pop_i,
  output logic [7:0]                       param_data_o,
  output logic [$clog2(PARAM_DEPTH+1)-1:0] param_cnt_o,
  output logic                             dma_en_o,
  output logic                             pio_en_o,
  input  logic                             stat_load_i,
  input  logic [STAT_BYTES*8-1:0]          stat_reply_i,
  input  logic                             subq_push_i,
  input  logic [7:0]                       subq_data_i,
  input  logic                             subq_overrun_i,
  input  logic                             xfer_phase_i,
  input  logic                             dma_busy_i,
  input  logic                             sub_ready_i,
  input  logic                             dma_done_i,
  output logic                             sub_irq_o,
  output logic                             dma_irq_o
);
  localparam int SCW = $clog2(STAT_BYTES + 1);
  localparam int QCW = $clog2(SUBQ_DEPTH + 1);

  logic wr_ctrl, wr_cmd, wr_param, wr_xfer;
  logic rd_stat, rd_subq;
  logic soft_rst;

  cmd_t cmd_q;
  logic cmd_vld_q;
  logic dma_en_q, pio_en_q;
  logic [IRQ_N-1:0] mask_q;

  logic [IRQ_N-1:0] irq_set, irq_clr, flag_vec, irq_vec;

  logic [BYTE_W-1:0] stat_byte, subq_byte;
  logic [SCW-1:0]    stat_cnt;
  logic              stat_nempty;
  logic [QCW-1:0]    subq_cnt;
  logic              subq_empty;
  logic              param_empty;

  assign wr_ctrl  = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_cmd   = wr_en_i && (addr_i == OFS_CMD);
  assign wr_param = wr_en_i && (addr_i == OFS_PARAM);
  assign wr_xfer  = wr_en_i && (addr_i == OFS_XFER);
  assign rd_stat  = rd_en_i && (addr_i == OFS_CMD);
  assign rd_subq  = rd_en_i && (addr_i == OFS_SUBDAT);
  assign soft_rst = wr_ctrl && wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      cmd_vld_q <= 1'b0;
      dma_en_q  <= 1'b0;
      pio_en_q  <= 1'b0;
      mask_q    <= '0;
    end else begin
      cmd_vld_q <= wr_cmd;
      if (wr_cmd) cmd_q <= cmd_t'(wdata_i);
      if (wr_xfer) begin
        dma_en_q <= wdata_i[4];
        pio_en_q <= wdata_i[3];
      end
      if (wr_ctrl) begin
        mask_q[IRQ_SUB] <= wdata_i[1];
        mask_q[IRQ_DMA] <= wdata_i[0];
      end
    end
  end

  assign irq_set[IRQ_SUB] = stat_load_i & cmd_q.irq_req;
  assign irq_set[IRQ_DMA] = dma_done_i;
  assign irq_clr[IRQ_SUB] = wr_ctrl & wdata_i[7];
  assign irq_clr[IRQ_DMA] = wr_ctrl & wdata_i[6];

  generate
    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
      cdc_hrif_irq u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .kill_i (soft_rst),
        .set_i  (irq_set[i]),
        .clr_i  (irq_clr[i]),
        .mask_i (mask_q[i]),
        .flag_o (flag_vec[i]),
        .irq_o  (irq_vec[i])
      );
    end
  endgenerate

  cdc_hrif_fifo #(
    .W(BYTE_W), .DEPTH(PARAM_DEPTH), .OVERWRITE(1'b1)
  ) u_param (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst),
    .push_i  (wr_param),
    .data_i  (wdata_i),
    .pop_i   (param_pop_i),
    .data_o  (param_data_o),
    .cnt_o   (param_cnt_o),
    .empty_o (param_empty)
  );

  cdc_hrif_fifo #(
    .W(BYTE_W), .DEPTH(SUBQ_DEPTH), .OVERWRITE(1'b0)
  ) u_subq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst),
    .push_i  (subq_push_i),
    .data_i  (subq_data_i),
    .pop_i   (rd_subq),
    .data_o  (subq_byte),
    .cnt_o   (subq_cnt),
    .empty_o (subq_empty)
  );

  cdc_hrif_statq #(
    .W(BYTE_W), .N(STAT_BYTES)
  ) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst),
    .load_i   (stat_load_i),
    .reply_i  (stat_reply_i),
    .pop_i    (rd_stat),
    .data_o   (stat_byte),
    .cnt_o    (stat_cnt),
    .nempty_o (stat_nempty)
  );

  always_comb begin
    unique case (addr_i)
      OFS_CTRL:   rdata_o = {flag_vec[IRQ_SUB], flag_vec[IRQ_DMA], xfer_phase_i,
                             dma_busy_i, 2'b00, stat_nempty, sub_ready_i};
      OFS_CMD:    rdata_o = stat_byte;
      OFS_SUBST:  rdata_o = {6'b0, subq_overrun_i, ~subq_empty};
      OFS_SUBDAT: rdata_o = subq_empty ? 8'h00 : subq_byte;
      default:    rdata_o = 8'hFF;
    endcase
  end

  assign cmd_valid_o    = cmd_vld_q;
  assign cmd_play_o     = cmd_q.play;
  assign cmd_irq_req_o  = cmd_q.irq_req;
  assign cmd_stat_req_o = cmd_q.stat_req;
  assign cmd_code_o     = cmd_q.code;
  assign dma_en_o       = dma_en_q;
  assign pio_en_o       = pio_en_q;
  assign sub_irq_o      = irq_vec[IRQ_SUB];
  assign dma_irq_o      = irq_vec[IRQ_DMA];
endmodule

// File: rtl/cdc_host_regs_chk.sv
module cdc_host_regs_chk #(
  parameter int PARAM_DEPTH = 8,
  parameter int STAT_BYTES  = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [3:0]                       addr_i,
  input logic [7:0]                       wdata_i,
  input logic                             cmd_valid_o,
  input logic                             cmd_irq_req_o,
  input logic [$clog2(PARAM_DEPTH+1)-1:0] param_cnt_o,
  input logic                             stat_load_i,
  input logic                             dma_done_i,
  input logic                             sub_irq_o,
  input logic                             sub_flag,
  input logic                             dma_flag,
  input logic [$clog2(STAT_BYTES+1)-1:0]  stat_cnt
);
  logic ctrl_wr, soft_wr;
  assign ctrl_wr = wr_en_i && (addr_i == 4'h0);
  assign soft_wr = ctrl_wr && wdata_i[2];

  assert_clear_sub_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[7] && !(stat_load_i && cmd_irq_req_o)) |=> !sub_flag);

  assert_mask_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[1]) |=> !sub_irq_o);

  assert_soft_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_wr |=> (param_cnt_o == '0) && (stat_cnt == '0) && !sub_flag && !dma_flag);

  assert_cmd_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(wr_en_i && (addr_i == 4'h2)));

  assert_param_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    param_cnt_o <= ($clog2(PARAM_DEPTH+1))'(PARAM_DEPTH));

  assert_load_fills_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_load_i && !soft_wr) |=> (stat_cnt == ($clog2(STAT_BYTES+1))'(STAT_BYTES)));

  assert_dma_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_done_i && !soft_wr) |=> dma_flag);
endmodule

bind cdc_host_regs cdc_host_regs_chk #(
  .PARAM_DEPTH(PARAM_DEPTH), .STAT_BYTES(STAT_BYTES)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_irq_req_o (cmd_irq_req_o),
  .param_cnt_o   (param_cnt_o),
  .stat_load_i   (stat_load_i),
  .dma_done_i    (dma_done_i),
  .sub_irq_o     (sub_irq_o),
  .sub_flag      (flag_vec[1]),
  .dma_flag      (flag_vec[0]),
  .stat_cnt      (stat_cnt)
);

// File: tb/cdc_host_regs_tb.sv
module cdc_host_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        cmd_valid_o, cmd_play_o, cmd_irq_req_o, cmd_stat_req_o;
  logic [4:0]  cmd_code_o;
  logic        param_pop_i = 1'b0;
  logic [7:0]  param_data_o;
  logic [3:0]  param_cnt_o;
  logic        dma_en_o, pio_en_o;
  logic        stat_load_i = 1'b0;
  logic [31:0] stat_reply_i = '0;
  logic        subq_push_i = 1'b0;
  logic [7:0]  subq_data_i = '0;
  logic        subq_overrun_i = 1'b0, xfer_phase_i = 1'b0, dma_busy_i = 1'b0;
  logic        sub_ready_i = 1'b0, dma_done_i = 1'b0;
  logic        sub_irq_o, dma_irq_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #5 clk_i = ~clk_i;

  cdc_host_regs dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic load(input logic [31:0] r);
    @(negedge clk_i); stat_load_i = 1'b1; stat_reply_i = r;
    @(negedge clk_i); stat_load_i = 1'b0;
  endtask

  task automatic dma_pulse();
    @(negedge clk_i); dma_done_i = 1'b1;
    @(negedge clk_i); dma_done_i = 1'b0;
  endtask

  task automatic subq_put(input logic [7:0] d);
    @(negedge clk_i); subq_push_i = 1'b1; subq_data_i = d;
    @(negedge clk_i); subq_push_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    rd(4'h0, rv);
    chk("reset R7 status", rv, 0);
    chk("reset R5 cnt", param_cnt_o, 0);
    chk("reset R2 irqs", {sub_irq_o, dma_irq_o}, 0);
    chk("reset R4 strobe", cmd_valid_o, 0);
    chk("reset R6 enables", {dma_en_o, pio_en_o}, 0);

    // R4: every command byte
    for (int b = 0; b < 256; b++) begin
      wr(4'h2, 8'(b));
      chk("R4 strobe high", cmd_valid_o, 1);
      chk("R4 fields", {cmd_play_o, cmd_irq_req_o, cmd_stat_req_o, cmd_code_o}, b);
      @(negedge clk_i);
      chk("R4 strobe one cycle", cmd_valid_o, 0);
    end

    // R6: every transfer byte
    for (int b = 0; b < 256; b++) begin
      wr(4'h6, 8'(b));
      chk("R6 enables", {dma_en_o, pio_en_o}, {b[4], b[3]});
    end

    // R12: unmapped reads
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 12 && a != 13) begin
        rd(4'(a), rv);
        chk("R12 unmapped read", rv, 8'hFF);
      end
    end

    // R13: writes elsewhere change nothing
    wr(4'h6, 8'h18);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 4 && a != 6) begin
        wr(4'(a), 8'hFF);
        chk("R13 no strobe", cmd_valid_o, 0);
        chk("R13 param cnt", param_cnt_o, 0);
        chk("R13 enables", {dma_en_o, pio_en_o}, 2'b11);
        rd(4'h0, rv);
        chk("R13 status", rv, 0);
      end
    end

    // R5: ordering without overflow
    for (int i = 0; i < 3; i++) wr(4'h4, 8'(8'h30 + i));
    chk("R5 cnt 3", param_cnt_o, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R5 order", param_data_o, 8'h30 + i);
      param_pop_i = 1'b1;
      @(negedge clk_i); param_pop_i = 1'b0;
    end
    chk("R5 drained", param_cnt_o, 0);

    // R5: overflow drops oldest
    for (int i = 0; i < 12; i++) begin
      wr(4'h4, 8'(8'h10 + i));
      chk("R5 fill level", param_cnt_o, (i + 1 > 8) ? 8 : i + 1);
    end
    for (int i = 4; i < 12; i++) begin
      @(negedge clk_i);
      chk("R5 overflow order", param_data_o, 8'h10 + i);
      param_pop_i = 1'b1;
      @(negedge clk_i); param_pop_i = 1'b0;
    end
    chk("R5 empty", param_cnt_o, 0);

    // R7: status input sweep
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      {xfer_phase_i, dma_busy_i, sub_ready_i} = 3'(i);
      rd(4'h0, rv);
      chk("R7 layout", rv, (i[2] << 5) | (i[1] << 4) | i[0]);
    end
    @(negedge clk_i);
    {xfer_phase_i, dma_busy_i, sub_ready_i} = 3'b000;

    // R8: reply order and flush
    wr(4'h2, 8'h00);
    load(32'h4433_2211);
    rd(4'h0, rv);
    chk("R8 available", rv, 8'h02);
    for (int i = 0; i < 4; i++) begin
      rd(4'h2, rv);
      chk("R8 byte order", rv, 8'h11 * (i + 1));
    end
    rd(4'h0, rv);
    chk("R8 drained", rv, 0);
    rd(4'h2, rv);
    chk("R12 empty status read", rv, 0);
    rd(4'h0, rv);
    chk("R12 still empty", rv, 0);
    load(32'hA4A3_A2A1);
    rd(4'h2, rv);
    chk("R8 partial", rv, 8'hA1);
    load(32'hB4B3_B2B1);
    for (int i = 0; i < 4; i++) begin
      rd(4'h2, rv);
      chk("R8 flush then reload", rv, 8'hB1 + i);
    end
    chk("R9 no reply irq", sub_irq_o, 0);

    // R9: reply interrupt
    wr(4'h2, 8'h40);
    load(32'h0102_0304);
    rd(4'h0, rv);
    chk("R9 flag set", rv, 8'h82);
    chk("R9 irq out", sub_irq_o, 1);

    // R2 / R1
    wr(4'h0, 8'h02);
    chk("R2 masked", sub_irq_o, 0);
    rd(4'h0, rv);
    chk("R2 flag visible", rv & 8'h80, 8'h80);
    wr(4'h0, 8'h00);
    chk("R2 unmasked", sub_irq_o, 1);
    wr(4'h0, 8'h80);
    rd(4'h0, rv);
    chk("R1 sub cleared", rv & 8'h80, 0);
    chk("R1 sub irq low", sub_irq_o, 0);

    // R10
    dma_pulse();
    rd(4'h0, rv);
    chk("R10 dma flag", rv & 8'h40, 8'h40);
    chk("R10 dma irq", dma_irq_o, 1);
    wr(4'h0, 8'h01);
    chk("R2 dma masked", dma_irq_o, 0);
    wr(4'h0, 8'h40);
    rd(4'h0, rv);
    chk("R1 dma cleared", rv & 8'h40, 0);
    dma_pulse();
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 4'h0; wdata_i = 8'h40; dma_done_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; dma_done_i = 1'b0;
    rd(4'h0, rv);
    chk("R10 set beats clear", rv & 8'h40, 8'h40);

    // R1/R2 sweep of clear and mask bits
    for (int m = 0; m < 16; m++) begin
      load(32'h0);
      dma_pulse();
      wr(4'h0, 8'((m[3] << 7) | (m[2] << 6) | (m[1] << 1) | m[0]));
      rd(4'h0, rv);
      chk("R1 sweep flags", rv & 8'hC0, ((m[3] ? 0 : 1) << 7) | ((m[2] ? 0 : 1) << 6));
      chk("R2 sweep sub irq", sub_irq_o, (!m[3] && !m[1]) ? 1 : 0);
      chk("R2 sweep dma irq", dma_irq_o, (!m[2] && !m[0]) ? 1 : 0);
    end

    // R3: soft reset
    for (int i = 0; i < 3; i++) wr(4'h4, 8'(i));
    subq_put(8'h55);
    subq_put(8'h66);
    load(32'h0);
    dma_pulse();
    wr(4'h0, 8'h04);
    chk("R3 param empty", param_cnt_o, 0);
    rd(4'h0, rv);
    chk("R3 status cleared", rv, 0);
    rd(4'hC, rv);
    chk("R3 subq empty", rv, 0);
    chk("R3 irqs low", {sub_irq_o, dma_irq_o}, 0);

    // R11: sub-code queue
    subq_put(8'hA1);
    subq_put(8'hA2);
    rd(4'hC, rv);
    chk("R11 not empty", rv, 8'h01);
    @(negedge clk_i); subq_overrun_i = 1'b1;
    rd(4'hC, rv);
    chk("R11 overrun", rv, 8'h03);
    @(negedge clk_i); subq_overrun_i = 1'b0;
    rd(4'hD, rv);
    chk("R11 first byte", rv, 8'hA1);
    rd(4'hD, rv);
    chk("R11 second byte", rv, 8'hA2);
    rd(4'hC, rv);
    chk("R11 empty", rv, 0);
    rd(4'hD, rv);
    chk("R11 empty read", rv, 0);

    finish_run();
  end
endmodule